// File: doc/BRIEF.md
# I2C Target Register-Access Controller

This block is an I2C target that never drives the clock line. It samples the bus clock and data lines with a fast system clock, finds start and stop conditions, and matches a 7-bit device address. The upper six address bits are a parameter. The lowest address bit comes from a board-level select pin. After a write-direction address, the first byte sets an internal subaddress pointer. Each later byte is handed to a register staging unit as one write, and the pointer advances after every byte. A repeated start followed by a read-direction address returns bytes from the stored pointer for as long as the controller keeps acknowledging.

The data line is driven through an open-drain output enable: `sda_oe` high pulls the line low. The back end is stream-like, but the bus cannot be stalled, so there is no back-pressure.
- A write is a single-cycle `wr_valid` pulse with `wr_addr` and `wr_data`. The staging unit must accept it in that cycle.
- A read is a single-cycle `rd_req` pulse with `rd_addr`. The staging unit must present `rd_data` on the cycle that follows the pulse, where it is captured once.

The `evt_start` and `evt_stop` pulses report every bus start and stop, so that a downstream unit can validate whole transactions.

Top module: `i2cs_regport`

## Requirements
- R1: Every bus start (SDA falling while SCL is high) gives a one-cycle `evt_start` pulse, and every bus stop (SDA rising while SCL is high) gives a one-cycle `evt_stop` pulse. The two pulses are never high together.
- R2: An address byte whose upper seven bits equal {010101, `addr_sel`} is acknowledged: `sda_oe` is high through the whole ninth clock of that byte. Bit 0 of the address byte is the direction (1 = read).
- R3: After an address byte that does not match, the controller acknowledges nothing, issues no write or read, and leaves SDA released until the next start.
- R4: In a write, the first byte after the address is acknowledged and loaded into the subaddress pointer, without a write pulse.
- R5: Each later write byte is acknowledged and produces exactly one `wr_valid` pulse, with `wr_addr` equal to the pointer. The pointer then increments, wrapping from 0xFF to 0x00.
- R6: A read-direction address issues `rd_req` with `rd_addr` equal to the stored pointer. `rd_data` is taken on the cycle after `rd_req`. `rd_req` and `wr_valid` are never high together.
- R7: Read bytes are sent MSB first from successive addresses while the controller acknowledges. A not-acknowledge ends the read: no further `rd_req` is issued and SDA stays released.
- R8: After reset, `sda_oe`, `wr_valid`, `rd_req` and both event pulses are low, and the pointer is 0.
- R9: `sda_oe` changes only in the cycle after a detected SCL fall, start or stop. It never changes while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level |
| addr_sel | input | 1 | Device address bit 0 |
| sda_oe | output | 1 | Pull SDA low when high |
| evt_start | output | 1 | Start condition pulse |
| evt_stop | output | 1 | Stop condition pulse |
| wr_valid | output | 1 | Register write pulse |
| wr_addr | output | 8 | Write subaddress |
| wr_data | output | 8 | Write byte |
| rd_req | output | 1 | Register read request pulse |
| rd_addr | output | 8 | Read subaddress |
| rd_data | input | 8 | Read byte, valid the cycle after rd_req |

## Verification
The hardest situation to reach from the ports is a read that starts at a pointer set by an earlier write. It needs a write-direction address, a subaddress byte with no data, a repeated start without a stop, and a read address, all timed as real bus bits. The bench's bus-master tasks build exactly that sequence. They acknowledge two bytes and refuse the third, so that the continuation path and the termination path are both taken. The wrap of the pointer is reached by setting it to 0xFE and streaming three bytes.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_ADDR_ACK, S_SUB, S_SUB_ACK,
    S_WR, S_WR_ACK, S_RD, S_RD_ACK
  } tgt_state_t;
endpackage

// File: rtl/i2cs_busmon.sv
module i2cs_busmon #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic bus_start,
  output logic bus_stop
);
  logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
  logic scl_q, sda_q, scl_s, sda_s;

  assign scl_s = scl_sr[SYNC_STAGES-1];
  assign sda_s = sda_sr[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign sda_lvl   = sda_s;
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
  assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2cs_shreg.sv
module i2cs_shreg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         rise_en,
  input  logic         rx_mode,
  input  logic         in_bit,
  input  logic         shift_out,
  output logic [W-1:0] data,
  output logic         full
);
  localparam int CW = $clog2(W);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      full <= 1'b0;
      data <= '0;
    end else if (load_en) begin
      cnt  <= '0;
      full <= 1'b0;
      data <= load_val;
    end else if (clr) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (rise_en) begin
      cnt  <= cnt + 1'b1;
      full <= (cnt == CW'(W - 1));
      if (rx_mode) data <= {data[W-2:0], in_bit};
    end else if (shift_out) begin
      data <= {data[W-2:0], 1'b0};
    end
  end
endmodule

// File: rtl/i2cs_regport.sv
module i2cs_regport
  import i2cs_pkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b010101,
  parameter int         SYNC_STAGES = 2,
  parameter int         AW          = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic              evt_start,
  output logic              evt_stop,
  output logic              wr_valid,
  output logic [AW-1:0]     wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic [AW-1:0]     rd_addr,
  input  logic [BYTE_W-1:0] rd_data
);
  logic sda_lvl, scl_rise, scl_fall, bus_start, bus_stop;
  tgt_state_t state;
  logic [AW-1:0] sub;
  logic rw, mack, rd_pend;
  logic [BYTE_W-1:0] hold, sh_data;
  logic sh_full, sh_clr, sh_load, sh_rise, sh_shift, rx_state, ack_state;

  i2cs_busmon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .bus_start(bus_start), .bus_stop(bus_stop)
  );

  assign rx_state  = (state == S_ADDR) || (state == S_SUB) || (state == S_WR);
  assign ack_state = (state == S_ADDR_ACK) || (state == S_SUB_ACK) || (state == S_WR_ACK);
  assign sh_clr    = bus_start | (scl_fall & (((state == S_ADDR_ACK) & ~rw) |
                     (state == S_SUB_ACK) | (state == S_WR_ACK)));
  assign sh_load   = scl_fall & (((state == S_ADDR_ACK) & rw) | ((state == S_RD_ACK) & mack));
  assign sh_rise   = scl_rise & (rx_state | (state == S_RD));
  assign sh_shift  = scl_fall & (state == S_RD) & ~sh_full;

  i2cs_shreg #(.W(BYTE_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clr(sh_clr), .load_en(sh_load), .load_val(hold),
    .rise_en(sh_rise), .rx_mode(rx_state), .in_bit(sda_lvl), .shift_out(sh_shift),
    .data(sh_data), .full(sh_full)
  );

  assign sda_oe = ack_state | ((state == S_RD) & ~sh_data[BYTE_W-1]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pend <= 1'b0;
      hold    <= '0;
    end else begin
      rd_pend <= rd_req;
      if (rd_pend) hold <= rd_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      sub       <= '0;
      rw        <= 1'b0;
      mack      <= 1'b0;
      evt_start <= 1'b0;
      evt_stop  <= 1'b0;
      wr_valid  <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
    end else begin
      evt_start <= bus_start;
      evt_stop  <= bus_stop;
      wr_valid  <= 1'b0;
      rd_req    <= 1'b0;
      if (bus_start) begin
        state <= S_ADDR;
      end else if (bus_stop) begin
        state <= S_IDLE;
      end else begin
        unique case (state)
          S_ADDR: if (scl_fall && sh_full) begin
            if (sh_data[BYTE_W-1:1] == {DEV_ADDR_HI, addr_sel}) begin
              rw    <= sh_data[0];
              state <= S_ADDR_ACK;
              if (sh_data[0]) begin
                rd_req  <= 1'b1;
                rd_addr <= sub;
              end
            end else begin
              state <= S_IDLE;
            end
          end
          S_ADDR_ACK: if (scl_fall) begin
            if (rw) begin
              state <= S_RD;
              sub   <= sub + 1'b1;
            end else begin
              state <= S_SUB;
            end
          end
          S_SUB: if (scl_fall && sh_full) begin
            sub   <= sh_data[AW-1:0];
            state <= S_SUB_ACK;
          end
          S_SUB_ACK: if (scl_fall) state <= S_WR;
          S_WR: if (scl_fall && sh_full) begin
            wr_valid <= 1'b1;
            wr_addr  <= sub;
            wr_data  <= sh_data;
            sub      <= sub + 1'b1;
            state    <= S_WR_ACK;
          end
          S_WR_ACK: if (scl_fall) state <= S_WR;
          S_RD: if (scl_fall && sh_full) state <= S_RD_ACK;
          S_RD_ACK: begin
            if (scl_rise) begin
              mack <= ~sda_lvl;
              if (!sda_lvl) begin
                rd_req  <= 1'b1;
                rd_addr <= sub;
              end
            end else if (scl_fall) begin
              if (mack) begin
                state <= S_RD;
                sub   <= sub + 1'b1;
              end else begin
                state <= S_IDLE;
              end
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_regport_chk.sv
module i2cs_regport_chk (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic wr_valid,
  input logic rd_req,
  input logic evt_start,
  input logic evt_stop,
  input logic scl_fall,
  input logic bus_start,
  input logic bus_stop
);
  // R1
  evt_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_start && evt_stop));
  // R1
  evt_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_start |=> !evt_start);
  // R5
  wr_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);
  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && rd_req));
  // R9
  oe_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || bus_start || bus_stop));
endmodule

bind i2cs_regport i2cs_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .wr_valid(wr_valid),
  .rd_req(rd_req), .evt_start(evt_start), .evt_stop(evt_stop),
  .scl_fall(scl_fall), .bus_start(bus_start), .bus_stop(bus_stop)
);

// File: tb/sim_i2cs_regport.sv
`timescale 1ns/1ps
module sim_i2cs_regport;
  localparam int Q = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic msda = 1'b1;
  logic addr_sel = 1'b0;
  logic sda_oe, evt_start, evt_stop, wr_valid, rd_req;
  logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
  logic sda_bus;

  int errors = 0;
  int checks = 0;
  int starts_seen = 0;
  int stops_seen = 0;
  bit finished = 0;
  logic [7:0] mem [256];
  logic [15:0] wr_q [$];
  logic [7:0] rd_q [$];

  always #2 clk = ~clk;
  assign sda_bus = msda & ~sda_oe;

  i2cs_regport u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .addr_sel(addr_sel),
    .sda_oe(sda_oe), .evt_start(evt_start), .evt_stop(evt_stop),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor / scoreboard plus a one-cycle-latency register responder
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
  end
  always @(posedge clk) begin
    if (rst_n) begin
      if (evt_start) starts_seen++;
      if (evt_stop) stops_seen++;
      if (wr_valid) begin
        mem[wr_addr] <= wr_data;
        if (wr_q.size() == 0) chk(0, "R3/R5 unexpected write", {wr_addr, wr_data}, 0);
        else begin
          logic [15:0] e;
          e = wr_q.pop_front();
          chk({wr_addr, wr_data} == e, "R5 write addr/data", {wr_addr, wr_data}, e);
        end
      end
      if (rd_req) begin
        rd_data <= mem[rd_addr];
        if (rd_q.size() == 0) chk(0, "R3/R7 unexpected rd_req", rd_addr, 0);
        else begin
          logic [7:0] e;
          e = rd_q.pop_front();
          chk(rd_addr == e, "R6 rd_addr", rd_addr, e);
        end
      end
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start_t();
    msda = 1'b1; wt(Q); scl = 1'b1; wt(Q); msda = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop_t();
    msda = 1'b0; wt(Q); scl = 1'b1; wt(Q); msda = 1'b1; wt(Q);
  endtask

  task automatic bit_t(input logic b, output logic smp);
    msda = b; wt(Q); scl = 1'b1; wt(Q); smp = sda_bus; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    logic s;
    for (int i = 7; i >= 0; i--) bit_t(b[i], s);
    bit_t(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_t(1'b1, s);
      b[i] = s;
    end
    bit_t(!give_ack, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    bit ak;
    logic [7:0] b;
    int st_exp;
    rd_data = 8'h00;
    wt(5);
    // R8 reset state
    chk(sda_oe == 0 && wr_valid == 0 && rd_req == 0 && evt_start == 0 && evt_stop == 0,
        "R8 reset outputs", {sda_oe, wr_valid, rd_req, evt_start, evt_stop}, 0);
    rst_n = 1'b1;
    wt(10);

    // R8 pointer is 0 after reset: read one byte, nack
    rd_q.push_back(8'h00);
    bus_start_t();
    send_byte(8'h55, ak);
    chk(ak, "R2 ack read addr sel=0", ak, 1);
    recv_byte(0, b);
    chk(b == 8'h5A, "R8 first read at pointer 0", b, 8'h5A);
    wt(2);
    chk(sda_oe == 0, "R7 SDA released after nack", sda_oe, 0);
    bus_stop_t();

    // R4/R5 write 3 bytes at 0x10
    wr_q.push_back({8'h10, 8'hA1});
    wr_q.push_back({8'h11, 8'hB2});
    wr_q.push_back({8'h12, 8'hC3});
    bus_start_t();
    send_byte(8'h54, ak); chk(ak, "R2 ack write addr", ak, 1);
    send_byte(8'h10, ak); chk(ak, "R4 ack subaddress", ak, 1);
    send_byte(8'hA1, ak); chk(ak, "R5 ack data 0", ak, 1);
    send_byte(8'hB2, ak); chk(ak, "R5 ack data 1", ak, 1);
    send_byte(8'hC3, ak); chk(ak, "R5 ack data 2", ak, 1);
    bus_stop_t();
    wt(4);
    chk(wr_q.size() == 0, "R5 all writes seen", wr_q.size(), 0);

    // R3 mismatch with sel=0
    bus_start_t();
    send_byte(8'h56, ak); chk(!ak, "R3 no ack on mismatch", ak, 0);
    send_byte(8'h33, ak); chk(!ak, "R3 ignored byte not acked", ak, 0);
    bus_stop_t();

    // R6/R7 set pointer, repeated start, read three
    rd_q.push_back(8'h10);
    rd_q.push_back(8'h11);
    rd_q.push_back(8'h12);
    bus_start_t();
    send_byte(8'h54, ak); chk(ak, "R2 ack", ak, 1);
    send_byte(8'h10, ak); chk(ak, "R4 ack subaddress only", ak, 1);
    bus_start_t();
    send_byte(8'h55, ak); chk(ak, "R6 ack read after repeated start", ak, 1);
    recv_byte(1, b); chk(b == 8'hA1, "R7 read byte 0", b, 8'hA1);
    recv_byte(1, b); chk(b == 8'hB2, "R7 read byte 1", b, 8'hB2);
    recv_byte(0, b); chk(b == 8'hC3, "R7 read byte 2", b, 8'hC3);
    wt(2);
    chk(sda_oe == 0, "R7 released after final nack", sda_oe, 0);
    bus_stop_t();
    wt(4);
    chk(rd_q.size() == 0, "R7 read request count", rd_q.size(), 0);

    // R2/R5 sel=1 and pointer wrap
    addr_sel = 1'b1;
    wr_q.push_back({8'hFE, 8'h11});
    wr_q.push_back({8'hFF, 8'h22});
    wr_q.push_back({8'h00, 8'h33});
    bus_start_t();
    send_byte(8'h56, ak); chk(ak, "R2 ack with sel=1", ak, 1);
    send_byte(8'hFE, ak);
    send_byte(8'h11, ak);
    send_byte(8'h22, ak);
    send_byte(8'h33, ak); chk(ak, "R5 ack after wrap", ak, 1);
    bus_stop_t();
    wt(4);
    chk(wr_q.size() == 0, "R5 wrap writes seen", wr_q.size(), 0);

    // R3 old address rejected with sel=1
    bus_start_t();
    send_byte(8'h54, ak); chk(!ak, "R3 sel=1 rejects 0x2A", ak, 0);
    send_byte(8'h77, ak); chk(!ak, "R3 ignored data", ak, 0);
    bus_stop_t();
    wt(6);

    // R1 event counts: 7 starts (incl. 1 repeated), 6 stops
    st_exp = 7;
    chk(starts_seen == st_exp, "R1 start pulses", starts_seen, st_exp);
    chk(stops_seen == 6, "R1 stop pulses", stops_seen, 6);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule